// File: doc/BRIEF.md
# Decoder-Controller Host Register Port

This block is the host-facing register file of an optical-disc data decoder/controller. The host reaches it through one 8-bit data path and a small address register. It first loads the address with an address strobe, then issues data reads or data writes. After each data access the address moves on by one, so that a run of registers can be transferred without reloading the address.

Reads and writes reach separate register maps that share the same 5-bit index space. Many accesses have side effects on an active-low interface status byte, which carries busy and interrupt flags. A four-deep command-input queue is filled from a separate valid/ready push port and drained by host reads of index 0. The block also holds a 12-bit byte count and a 16-bit transfer start address. It presents both to the transfer engine.

The push port follows these rules. `cmd_ready` is high whenever the queue holds fewer than `CMD_DEPTH` bytes. A byte is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A byte offered while `cmd_ready` is low is discarded, and the producer must not rely on it being kept. If the address strobe, a data write and a data read arrive in the same cycle, only one of them takes effect, in this priority: address strobe, then write, then read.

Top module: `dec_regif`

## Requirements
- R1: An address strobe loads the address register with `host_din[4:0]`. The upper three bits are ignored.
- R2: Every data read or data write at a non-zero index advances the address by one. The address wraps from 31 to 0. A read or write at index 0 leaves the address at 0.
- R3: A read at index 0 returns the oldest queued command byte and removes it from the queue. When the queue is empty, the read returns 0xFF and the queue is unchanged.
- R4: Status bit 7 (command interrupt, 0 = pending) goes to 1 when a read removes the last queued byte. It goes to 0 when the push port accepts a byte.
- R5: After reset the status byte is 0xFF and the queue is empty. A write to index 15 restores the status byte to 0xFF and empties the queue.
- R6: A write to index 1 stores the control byte. If control bit 0 is 0, status bit 2 (subcode busy) is set to 1. If control bit 1 is 0, status bit 3 (data busy) is set to 1.
- R7: A write to index 0 clears status bit 2, but only while control bit 0 is 1.
- R8: A write to index 6 with data bit 1 set clears status bit 3. With data bit 1 clear it does nothing. Any write to index 7 sets status bit 6 (transfer-end interrupt) to 1.
- R9: A read of index 15 sets status bit 5 (decoder interrupt) to 1.
- R10: Writes to indices 2 and 3 set the low and high bytes of the byte count. The high byte keeps only its low 4 bits, so the count is 12 bits wide. Indices 2 and 3 read these values back. Writes to indices 4 and 5 set the low and high bytes of the 16-bit transfer address.
- R11: Writes to indices 8 and 9 set the low and high bytes of the write-address register, which reads back at indices 10 and 11. Writes to indices 12 and 13 set the low and high bytes of the pointer register, which reads back at indices 8 and 9.
- R12: A read at any index of 16 or more returns 0xFF. Indices 4 to 7 and 12 to 15 read 0x00 in this block. Index 1 reads the status byte.
- R13: `cmd_ready` is low exactly when the queue holds `CMD_DEPTH` bytes. A push offered while `cmd_ready` is low is dropped. `cmd_level` shows the number of bytes held.
- R14: A high `dec_event` clears status bit 5, and a high `xfer_done` clears status bit 6. A register side effect in the same cycle takes precedence over these pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Load the address register from host_din |
| wr_en | input | 1 | Data write at the current address |
| rd_en | input | 1 | Data read at the current address (side effects at the clock edge) |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Read data for the current address (combinational) |
| cmd_valid | input | 1 | Command byte offered |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Queue can accept a byte |
| cmd_level | output | $clog2(CMD_DEPTH+1) | Bytes held in the queue |
| dec_event | input | 1 | Decoder interrupt event (clears status bit 5) |
| xfer_done | input | 1 | Transfer finished (clears status bit 6) |
| byte_cnt | output | 12 | Byte count |
| xfer_addr | output | 16 | Transfer start address |

## Verification
The hardest cases to reach from the ports are the flag transitions that need a flag in its asserted (0) state first. All three interrupt flags leave reset at 1. Bit 7 only drops after a push and bit 5 only after a `dec_event` pulse. The bench therefore pulses those pins, or fills the queue, before each access whose job is to return a flag to 1. It also loads the address at 31 and relies on the wrap to land on index 0. The queued byte read there proves that the wrap happened and that no increment followed the read.

// File: rtl/dec_regif_pkg.sv
package dec_regif_pkg;
  localparam int AW = 5;
  typedef logic [AW-1:0] idx_t;

  // write-side indices
  localparam idx_t W_SUBOUT  = 5'd0;
  localparam idx_t W_CTRL    = 5'd1;
  localparam idx_t W_CNT_LO  = 5'd2;
  localparam idx_t W_CNT_HI  = 5'd3;
  localparam idx_t W_XA_LO   = 5'd4;
  localparam idx_t W_XA_HI   = 5'd5;
  localparam idx_t W_TRIG    = 5'd6;
  localparam idx_t W_ACK     = 5'd7;
  localparam idx_t W_WA_LO   = 5'd8;
  localparam idx_t W_WA_HI   = 5'd9;
  localparam idx_t W_PT_LO   = 5'd12;
  localparam idx_t W_PT_HI   = 5'd13;
  localparam idx_t W_SOFTRST = 5'd15;

  // read-side indices
  localparam idx_t R_CMD    = 5'd0;
  localparam idx_t R_STAT   = 5'd1;
  localparam idx_t R_CNT_LO = 5'd2;
  localparam idx_t R_CNT_HI = 5'd3;
  localparam idx_t R_PT_LO  = 5'd8;
  localparam idx_t R_PT_HI  = 5'd9;
  localparam idx_t R_WA_LO  = 5'd10;
  localparam idx_t R_WA_HI  = 5'd11;
  localparam idx_t R_LAST   = 5'd15;

  // status bit positions (all active low)
  localparam int ST_SUB_BUSY = 2;
  localparam int ST_DAT_BUSY = 3;
  localparam int ST_DEC_IRQ  = 5;
  localparam int ST_END_IRQ  = 6;
  localparam int ST_CMD_IRQ  = 7;
endpackage

// File: rtl/dec_regif_addr.sv
module dec_regif_addr #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          access,
  output logic [AW-1:0] addr
);
  logic hold;
  assign hold = (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr <= '0;
    else if (load)             addr <= load_val;
    else if (access && !hold)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/dec_regif_cmdq.sv
module dec_regif_cmdq #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          push_acc,
  output logic          drained
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic          push_ok, pop_ok;

  assign push_ready = (level != FULL);
  assign push_ok    = push_valid && push_ready && !clear;
  assign pop_ok     = pop && (level != '0) && !clear;
  assign head       = mem[rp];
  assign push_acc   = push_ok;
  assign drained    = pop_ok && (level == ONE) && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0;
      wp <= '0;
      level <= '0;
    end else if (clear) begin
      rp <= '0;
      wp <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wp == PW'(i)) mem[i] <= push_data;
    end
  end
endmodule

// File: rtl/dec_regif_status.sv
module dec_regif_status
  import dec_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_val,
  input  logic       sub_wr,
  input  logic       sub_en,
  input  logic       trig_wr,
  input  logic       trig_bit,
  input  logic       ack_wr,
  input  logic       last_rd,
  input  logic       q_drained,
  input  logic       q_push,
  input  logic       dec_event,
  input  logic       xfer_done,
  output logic [7:0] status
);
  logic [7:0] nxt;

  always_comb begin
    nxt = status;
    // pin events first, so register side effects win
    if (dec_event) nxt[ST_DEC_IRQ] = 1'b0;
    if (xfer_done) nxt[ST_END_IRQ] = 1'b0;
    if (q_push)    nxt[ST_CMD_IRQ] = 1'b0;
    if (ctrl_wr) begin
      if (!ctrl_val[0]) nxt[ST_SUB_BUSY] = 1'b1;
      if (!ctrl_val[1]) nxt[ST_DAT_BUSY] = 1'b1;
    end
    if (sub_wr && sub_en)    nxt[ST_SUB_BUSY] = 1'b0;
    if (trig_wr && trig_bit) nxt[ST_DAT_BUSY] = 1'b0;
    if (ack_wr)    nxt[ST_END_IRQ] = 1'b1;
    if (last_rd)   nxt[ST_DEC_IRQ] = 1'b1;
    if (q_drained) nxt[ST_CMD_IRQ] = 1'b1;
    if (soft_rst)  nxt = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 8'hFF;
    else        status <= nxt;
  end
endmodule

// File: rtl/dec_regif.sv
module dec_regif
  import dec_regif_pkg::*;
#(
  parameter int CMD_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           addr_wr,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [7:0]                     host_din,
  output logic [7:0]                     host_dout,
  input  logic                           cmd_valid,
  input  logic [7:0]                     cmd_data,
  output logic                           cmd_ready,
  output logic [$clog2(CMD_DEPTH+1)-1:0] cmd_level,
  input  logic                           dec_event,
  input  logic                           xfer_done,
  output logic [11:0]                    byte_cnt,
  output logic [15:0]                    xfer_addr
);
  idx_t       cur_addr;
  logic       acc_wr, acc_rd;
  logic [7:0] ctrl_q, cnt_lo, q_head, status_q;
  logic [3:0] cnt_hi;
  logic [15:0] wa_q, pt_q;
  logic       q_acc, q_drained;

  assign acc_wr = wr_en && !addr_wr;
  assign acc_rd = rd_en && !addr_wr && !wr_en;

  dec_regif_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(addr_wr), .load_val(host_din[AW-1:0]),
    .access(acc_wr || acc_rd), .addr(cur_addr)
  );

  dec_regif_cmdq #(.DEPTH(CMD_DEPTH), .W(8)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .clear(acc_wr && cur_addr == W_SOFTRST),
    .push_valid(cmd_valid), .push_data(cmd_data), .push_ready(cmd_ready),
    .pop(acc_rd && cur_addr == R_CMD),
    .head(q_head), .level(cmd_level),
    .push_acc(q_acc), .drained(q_drained)
  );

  dec_regif_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .soft_rst(acc_wr && cur_addr == W_SOFTRST),
    .ctrl_wr(acc_wr && cur_addr == W_CTRL), .ctrl_val(host_din[1:0]),
    .sub_wr(acc_wr && cur_addr == W_SUBOUT), .sub_en(ctrl_q[0]),
    .trig_wr(acc_wr && cur_addr == W_TRIG), .trig_bit(host_din[1]),
    .ack_wr(acc_wr && cur_addr == W_ACK),
    .last_rd(acc_rd && cur_addr == R_LAST),
    .q_drained(q_drained), .q_push(q_acc),
    .dec_event(dec_event), .xfer_done(xfer_done),
    .status(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_lo    <= '0;
      cnt_hi    <= '0;
      xfer_addr <= '0;
      wa_q      <= '0;
      pt_q      <= '0;
    end else if (acc_wr) begin
      case (cur_addr)
        W_CTRL:   ctrl_q          <= host_din;
        W_CNT_LO: cnt_lo          <= host_din;
        W_CNT_HI: cnt_hi          <= host_din[3:0];
        W_XA_LO:  xfer_addr[7:0]  <= host_din;
        W_XA_HI:  xfer_addr[15:8] <= host_din;
        W_WA_LO:  wa_q[7:0]       <= host_din;
        W_WA_HI:  wa_q[15:8]      <= host_din;
        W_PT_LO:  pt_q[7:0]       <= host_din;
        W_PT_HI:  pt_q[15:8]      <= host_din;
        default:  ;
      endcase
    end
  end

  assign byte_cnt = {cnt_hi, cnt_lo};

  always_comb begin
    if (cur_addr[AW-1]) host_dout = 8'hFF;
    else begin
      case (cur_addr)
        R_CMD:    host_dout = (cmd_level == '0) ? 8'hFF : q_head;
        R_STAT:   host_dout = status_q;
        R_CNT_LO: host_dout = cnt_lo;
        R_CNT_HI: host_dout = {4'h0, cnt_hi};
        R_PT_LO:  host_dout = pt_q[7:0];
        R_PT_HI:  host_dout = pt_q[15:8];
        R_WA_LO:  host_dout = wa_q[7:0];
        R_WA_HI:  host_dout = wa_q[15:8];
        default:  host_dout = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dec_regif_chk.sv
module dec_regif_chk #(
  parameter int CMD_DEPTH = 4,
  parameter int AW = 5,
  localparam int LW = $clog2(CMD_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_wr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    host_din,
  input logic [7:0]    host_dout,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [LW-1:0] cmd_level,
  input logic [AW-1:0] addr,
  input logic [7:0]    status
);
  localparam logic [LW-1:0] FULL = LW'(CMD_DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);
  localparam logic [AW-1:0] HI   = AW'(16);
  localparam logic [AW-1:0] LAST = AW'(15);

  a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> addr == $past(host_din[AW-1:0]));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && (wr_en || rd_en) && addr != '0) |=> addr == AW'($past(addr) + 1'b1));

  a_r2_addr_hold0: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && addr == '0) |=> addr == '0);

  a_r3_empty_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0 && cmd_level == '0) |-> host_dout == 8'hFF);

  a_r4_drain_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !addr_wr && addr == '0 && cmd_level == ONE && !cmd_valid)
      |=> status[7]);

  a_r5_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_wr && addr == LAST) |=> (status == 8'hFF && cmd_level == '0));

  a_r12_high_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= HI) |-> host_dout == 8'hFF);

  a_r13_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_level == FULL) |-> !cmd_ready);

  a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_level <= FULL);
endmodule

bind dec_regif dec_regif_chk #(.CMD_DEPTH(CMD_DEPTH), .AW(dec_regif_pkg::AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .wr_en(wr_en), .rd_en(rd_en),
  .host_din(host_din), .host_dout(host_dout), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_level(cmd_level), .addr(cur_addr), .status(status_q)
);

// File: tb/dec_regif_tb.sv
module dec_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_wr, wr_en, rd_en;
  logic [7:0] host_din, host_dout;
  logic       cmd_valid, cmd_ready;
  logic [7:0] cmd_data;
  logic [2:0] cmd_level;
  logic       dec_event, xfer_done;
  logic [11:0] byte_cnt;
  logic [15:0] xfer_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_regif u_dut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .wr_en(wr_en), .rd_en(rd_en),
    .host_din(host_din), .host_dout(host_dout), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .cmd_level(cmd_level),
    .dec_event(dec_event), .xfer_done(xfer_done),
    .byte_cnt(byte_cnt), .xfer_addr(xfer_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    addr_wr = 1'b1; host_din = a;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; host_din = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_en = 1'b1;
    #1 v = host_dout;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, output logic rdy);
    cmd_valid = 1'b1; cmd_data = d;
    #1 rdy = cmd_ready;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_stat(input string req, input logic [7:0] exp);
    logic [7:0] v;
    set_addr(8'd1);
    rd(v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R5 queue empty", cmd_level, 0);
    chk("R13 ready", cmd_ready, 1);
    chk("R10 xfer addr", xfer_addr, 0);
    read_stat("R5 status after reset", 8'hFF);
  endtask

  task automatic t_ctrl;
    set_addr(8'd1); wr(8'h03);
    set_addr(8'd0); wr(8'hAA);
    set_addr(8'd6); wr(8'h02);
    read_stat("R7 R8 busy cleared", 8'hF3);
    set_addr(8'd6); wr(8'h00);
    read_stat("R8 trigger without bit1", 8'hF3);
    set_addr(8'd1); wr(8'h00);
    read_stat("R6 busy set", 8'hFF);
    set_addr(8'd0); wr(8'h55);
    read_stat("R7 subcode write disabled", 8'hFF);
  endtask

  task automatic t_flags;
    logic [7:0] v;
    dec_event = 1'b1; xfer_done = 1'b1;
    @(negedge clk);
    dec_event = 1'b0; xfer_done = 1'b0;
    read_stat("R14 pin clears", 8'h9F);
    set_addr(8'd7); wr(8'h00);
    read_stat("R8 ack sets bit6", 8'hDF);
    set_addr(8'd15); rd(v);
    chk("R12 index 15 reads zero", v, 8'h00);
    read_stat("R9 status3 read sets bit5", 8'hFF);
  endtask

  task automatic t_cmd;
    logic r;
    logic [7:0] v;
    for (int i = 1; i <= 4; i++) begin
      push(8'(i * 8'h11), r);
      chk("R13 ready while not full", r, 1);
    end
    push(8'h55, r);
    chk("R13 ready low when full", r, 0);
    chk("R13 level", cmd_level, 4);
    read_stat("R4 push clears bit7", 8'h7F);
    set_addr(8'd0);
    for (int i = 1; i <= 3; i++) begin
      rd(v);
      chk("R3 oldest first", v, 8'(i * 8'h11));
    end
    read_stat("R4 not drained yet", 8'h7F);
    set_addr(8'd0);
    rd(v); chk("R13 full push dropped", v, 8'h44);
    rd(v); chk("R3 empty read", v, 8'hFF);
    chk("R3 level", cmd_level, 0);
    read_stat("R4 drain sets bit7", 8'hFF);
  endtask

  task automatic t_softrst;
    logic r;
    logic [7:0] v;
    push(8'h66, r); push(8'h77, r);
    dec_event = 1'b1; @(negedge clk); dec_event = 1'b0;
    set_addr(8'd15); wr(8'h00);
    chk("R5 soft reset level", cmd_level, 0);
    read_stat("R5 soft reset status", 8'hFF);
    set_addr(8'd0); rd(v);
    chk("R5 queue cleared", v, 8'hFF);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    set_addr(8'd2); wr(8'hCD); wr(8'hAB);
    chk("R10 byte count", byte_cnt, 12'hBCD);
    set_addr(8'd2);
    rd(v); chk("R10 count low read", v, 8'hCD);
    rd(v); chk("R10 count high read", v, 8'h0B);
    wr(8'h34); wr(8'h12);
    chk("R10 xfer addr", xfer_addr, 16'h1234);
  endtask

  task automatic t_cross;
    logic [7:0] v;
    set_addr(8'd8); wr(8'h11); wr(8'h22);
    set_addr(8'd12); wr(8'h33); wr(8'h44);
    set_addr(8'd8);
    rd(v); chk("R11 pointer low at 8", v, 8'h33);
    rd(v); chk("R11 pointer high at 9", v, 8'h44);
    rd(v); chk("R11 write addr low at 10", v, 8'h11);
    rd(v); chk("R11 write addr high at 11", v, 8'h22);
  endtask

  task automatic t_wrap;
    logic r;
    logic [7:0] v;
    set_addr(8'd16); rd(v);
    chk("R12 index 16", v, 8'hFF);
    set_addr(8'd31); rd(v);
    chk("R12 index 31", v, 8'hFF);
    push(8'h5A, r); push(8'hA5, r);
    rd(v); chk("R2 wrap to zero", v, 8'h5A);
    rd(v); chk("R2 hold at zero", v, 8'hA5);
    set_addr(8'hE8); rd(v);
    chk("R1 upper bits ignored", v, 8'h33);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_wr = 0; wr_en = 0; rd_en = 0; host_din = 0;
    cmd_valid = 0; cmd_data = 0; dec_event = 0; xfer_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_flags();
    t_cmd();
    t_softrst();
    t_regs();
    t_cross();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule